// File: doc/BRIEF.md
# Extended-Color Pixel Serializer

This block turns a stream of 16-bit display words into per-dot digital red, green and blue levels for a low-resolution mode that carries four bits per pixel. Each word holds four pixels. Three bits of every pixel drive the colour lines directly, which gives the eight basic colours. The fourth bit is an extra bit whose meaning depends on a mode input.

In the extended-colour mode, a set extra bit splits the pixel into two half-width dots. The first dot shows the pixel's own colour and the second shows its bitwise complement, so a stipple gives the look of more colours. In the fill mode, the extra bit opens or closes a filled run on the current scan line. Inside an open run, every ordinary pixel takes the colour latched when the run opened. In the plain mode, the extra bit is ignored.

The timing generator upstream supplies the load strobe, one dot enable per half-pixel, and a line-start pulse. There is no intensity line and no analog mixing.

Top module: `xpix_serializer`

## Requirements
- R1: After a synchronous reset, all three colour outputs are 0 and no fill run is open.
- R2: Pixel k (k = 0 is the most significant and is shown first) takes G from word bit 15-2k, X (the extra bit) from bit 14-2k, R from bit 7-2k and B from bit 6-2k. This mapping is the same in every mode.
- R3: The outputs are registered. They change only at a clock edge where `dot_en_i` is high and `load_i` is low. Each such edge presents one half-pixel, two half-pixels make one pixel, and pixels advance in order 0 to 3.
- R4: Modes 2'b00 and 2'b11 are plain. Both halves show the pixel's RGB and the X bit has no effect.
- R5: In mode 2'b01 (extended), a pixel with X=0 shows its own RGB in both halves.
- R6: In mode 2'b01, a pixel with X=1 shows its own RGB in the first half and the bitwise complement of that RGB in the second half.
- R7: In mode 2'b10 (fill), a pixel with X=1 shows its own RGB in both halves and toggles the fill run at its first half. When the run opens, that pixel's RGB is latched as the fill colour.
- R8: In mode 2'b10, while a fill run is open, a pixel with X=0 shows the latched fill colour in both halves.
- R9: A `line_start_i` pulse closes any open fill run, and it wins over a toggle in the same cycle.
- R10: `load_i` captures a new word and restarts at pixel 0, first half. It takes priority over `dot_en_i` and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 16 | Fetched display word |
| load_i | input | 1 | Capture `word_i` and restart at pixel 0 |
| dot_en_i | input | 1 | Present the next half-pixel |
| line_start_i | input | 1 | Start of a scan line; closes any fill run |
| mode_i | input | 2 | 00/11 plain, 01 extended colour, 10 fill |
| r_o | output | 1 | Red level |
| g_o | output | 1 | Green level |
| b_o | output | 1 | Blue level |

## Verification
The complement check for R6 assumes that `mode_i` does not change between the two halves of one pixel, and that no load falls between them. The bench changes the mode only between words, and issues a load only after all eight half-pixels of a word have been shown. The assertions also assume that load and dot enable are never high together. The stimulus keeps them in separate cycles and adds idle cycles between dots to check that the outputs hold. The sweep places every 4-bit pixel value in every slot under every mode, with line starts on alternate words, so fill runs both cross word boundaries and are cut off by a line start.

// File: rtl/xpix_pkg.sv
package xpix_pkg;

    localparam int WORD_W       = 16;
    localparam int BYTE_W       = WORD_W / 2;
    localparam int BITS_PER_BYT = 2;
    localparam int PIX_PER_WORD = BYTE_W / BITS_PER_BYT;
    localparam int IDX_W        = $clog2(PIX_PER_WORD);
    localparam int RGB_W        = 3;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_EXT   = 2'b01,
        MODE_FILL  = 2'b10,
        MODE_ALT   = 2'b11
    } mode_e;

    typedef struct packed {
        logic             x;
        logic [RGB_W-1:0] rgb;   // {r, g, b}
    } pix_t;

    function automatic logic is_fill(input mode_e m);
        return m == MODE_FILL;
    endfunction

    function automatic logic is_ext(input mode_e m);
        return m == MODE_EXT;
    endfunction

endpackage

// File: rtl/xpix_unpack.sv
module xpix_unpack
    import xpix_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    output pix_t              pix_o
);
    pix_t slots [PIX_PER_WORD];

    for (genvar k = 0; k < PIX_PER_WORD; k++) begin : g_slot
        localparam int HI = BYTE_W - 1 - BITS_PER_BYT * k;
        assign slots[k].x      = word_i[BYTE_W + HI - 1];
        assign slots[k].rgb[1] = word_i[BYTE_W + HI];
        assign slots[k].rgb[2] = word_i[HI];
        assign slots[k].rgb[0] = word_i[HI - 1];
    end

    assign pix_o = slots[idx_i];
endmodule

// File: rtl/xpix_fill.sv
module xpix_fill
    import xpix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start_i,
    input  logic             toggle_i,
    input  logic [RGB_W-1:0] color_i,
    output logic             active_o,
    output logic [RGB_W-1:0] color_o
);
    logic             active_q;
    logic [RGB_W-1:0] color_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            color_q  <= '0;
        end else if (line_start_i) begin
            active_q <= 1'b0;
        end else if (toggle_i) begin
            active_q <= !active_q;
            if (!active_q) color_q <= color_i;
        end
    end

    assign active_o = active_q;
    assign color_o  = color_q;

    // R9: a line start always closes the run
    p_line_clear_r9: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> !active_o);

    // R7: opening a run latches the opening pixel colour
    p_open_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (toggle_i && !line_start_i && !active_o) |=> (active_o && color_o == $past(color_i)));

    // R7: without toggle or line start the run state holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!toggle_i && !line_start_i) |=> ($stable(active_o) && $stable(color_o)));
endmodule

// File: rtl/xpix_color_sel.sv
module xpix_color_sel
    import xpix_pkg::*;
(
    input  mode_e            mode_i,
    input  logic             second_half_i,
    input  pix_t             pix_i,
    input  logic             fill_active_i,
    input  logic [RGB_W-1:0] fill_color_i,
    output logic [RGB_W-1:0] rgb_o
);
    always_comb begin
        rgb_o = pix_i.rgb;
        unique case (mode_i)
            MODE_EXT: begin
                if (pix_i.x && second_half_i) rgb_o = ~pix_i.rgb;
            end
            MODE_FILL: begin
                if (!pix_i.x && fill_active_i) rgb_o = fill_color_i;
            end
            MODE_PLAIN, MODE_ALT: rgb_o = pix_i.rgb;
            default: rgb_o = pix_i.rgb;
        endcase
    end
endmodule

// File: rtl/xpix_serializer.sv
module xpix_serializer
    import xpix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    input  logic              dot_en_i,
    input  logic              line_start_i,
    input  logic [1:0]        mode_i,
    output logic              r_o,
    output logic              g_o,
    output logic              b_o
);
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              half_q;
    logic [RGB_W-1:0]  rgb_q;

    mode_e            mode;
    pix_t             cur_pix;
    logic             emit;
    logic             fill_toggle;
    logic             fill_active;
    logic [RGB_W-1:0] fill_color;
    logic [RGB_W-1:0] next_rgb;

    assign mode = mode_e'(mode_i);
    assign emit = dot_en_i && !load_i;
    assign fill_toggle = emit && !half_q && is_fill(mode) && cur_pix.x;

    xpix_unpack u_unpack (
        .word_i (word_q),
        .idx_i  (idx_q),
        .pix_o  (cur_pix)
    );

    xpix_fill u_fill (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start_i),
        .toggle_i     (fill_toggle),
        .color_i      (cur_pix.rgb),
        .active_o     (fill_active),
        .color_o      (fill_color)
    );

    xpix_color_sel u_sel (
        .mode_i        (mode),
        .second_half_i (half_q),
        .pix_i         (cur_pix),
        .fill_active_i (fill_active),
        .fill_color_i  (fill_color),
        .rgb_o         (next_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            half_q <= 1'b0;
            rgb_q  <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            idx_q  <= '0;
            half_q <= 1'b0;
        end else if (dot_en_i) begin
            rgb_q  <= next_rgb;
            half_q <= !half_q;
            if (half_q) idx_q <= idx_q + 1'b1;
        end
    end

    assign {r_o, g_o, b_o} = rgb_q;

    // R3: outputs move only on an emitting edge
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !emit |=> $stable({r_o, g_o, b_o}));

    // R4: plain modes repeat the first half in the second
    p_plain_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (emit && half_q && (mode == MODE_PLAIN || mode == MODE_ALT)) |=> $stable({r_o, g_o, b_o}));

    // R6: extended pixel with X set ends on the complement of its first half
    p_ext_complement_r6: assert property (@(posedge clk) disable iff (rst)
        (emit && half_q && is_ext(mode) && cur_pix.x) |=> ({r_o, g_o, b_o} == ~$past({r_o, g_o, b_o})));

    // R10: load never coincides with a dot in the stimulus contract
    p_load_dot_excl_r10: assert property (@(posedge clk) disable iff (rst)
        load_i |=> $stable({r_o, g_o, b_o}));
endmodule

// File: tb/xpix_serializer_test.sv
module xpix_serializer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word_i = '0;
    logic        load_i = 1'b0;
    logic        dot_en_i = 1'b0;
    logic        line_start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        r_o, g_o, b_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic       m_fill;
    logic [2:0] m_col;
    logic [2:0] last_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpix_serializer uut (
        .clk(clk), .rst(rst), .word_i(word_i), .load_i(load_i),
        .dot_en_i(dot_en_i), .line_start_i(line_start_i), .mode_i(mode_i),
        .r_o(r_o), .g_o(g_o), .b_o(b_o)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // R2: pixel value nibble is {x, r, g, b}
    function automatic logic [15:0] pack(input logic [3:0] p0, input logic [3:0] p1,
                                         input logic [3:0] p2, input logic [3:0] p3);
        logic [3:0]  v [4];
        logic [15:0] w;
        v[0] = p0; v[1] = p1; v[2] = p2; v[3] = p3;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            w[15-2*k] = v[k][1];
            w[14-2*k] = v[k][3];
            w[7-2*k]  = v[k][2];
            w[6-2*k]  = v[k][0];
        end
        return w;
    endfunction

    // expected half-pixel colour from R4..R8
    function automatic logic [2:0] model(input logic [1:0] m, input logic [3:0] v, input int h);
        logic [2:0] c;
        c = v[2:0];
        case (m)
            2'b01: return (v[3] && h == 1) ? ~c : c;
            2'b10: begin
                if (h == 0 && v[3]) begin
                    if (!m_fill) begin m_fill = 1'b1; m_col = c; end
                    else m_fill = 1'b0;
                end
                return v[3] ? c : (m_fill ? m_col : c);
            end
            default: return c;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] m, input logic [3:0] v);
        if (m == 2'b00 || m == 2'b11) return "R4";
        if (m == 2'b01) return v[3] ? "R6" : "R5";
        return v[3] ? "R7" : "R8";
    endfunction

    task automatic run_word(input logic [1:0] m, input logic [3:0] px [4], input logic ls);
        @(negedge clk);
        word_i = pack(px[0], px[1], px[2], px[3]);
        load_i = 1'b1;
        line_start_i = ls;
        mode_i = m;
        @(negedge clk);
        load_i = 1'b0;
        line_start_i = 1'b0;
        if (ls) m_fill = 1'b0;  // R9
        check("R10", {r_o, g_o, b_o}, last_out);
        for (int k = 0; k < 4; k++) begin
            for (int h = 0; h < 2; h++) begin
                logic [2:0] exp;
                exp = model(m, px[k], h);
                dot_en_i = 1'b1;
                @(negedge clk);
                dot_en_i = 1'b0;
                check(tag_for(m, px[k]), {r_o, g_o, b_o}, exp);  // R2 R3
                last_out = exp;
                if (k == 1 && h == 0) begin
                    @(negedge clk);
                    check("R3", {r_o, g_o, b_o}, exp);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [3:0] px [4];
        m_fill = 1'b0;
        m_col = '0;
        last_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {r_o, g_o, b_o}, 3'b000);
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 16; v++) begin
                for (int pos = 0; pos < 4; pos++) begin
                    for (int k = 0; k < 4; k++)
                        px[k] = (k == pos) ? 4'(v) : 4'((v * 5 + k * 3 + pos) & 15);
                    run_word(2'(m), px, ((v + pos) % 2) == 0);
                end
            end
        end
        // R9: line start alone, mid-run, closes the run
        px[0] = 4'b1_101; px[1] = 4'b0_010; px[2] = 4'b0_011; px[3] = 4'b0_100;
        run_word(2'b10, px, 1'b1);
        @(negedge clk);
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
        m_fill = 1'b0;
        px[0] = 4'b0_110; px[1] = 4'b0_001; px[2] = 4'b0_000; px[3] = 4'b0_111;
        run_word(2'b10, px, 1'b0);
        // R1: reset returns outputs to black
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", {r_o, g_o, b_o}, 3'b000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule